// File: doc/BRIEF.md
# UART receiver with status flags

This block is the receive half of an asynchronous serial port for a small microcontroller peripheral. It watches an asynchronous RX line using a sample tick at sixteen times the bit rate. It finds the falling edge of a start bit and checks that the start bit is real. It then collects eight data bits, least significant bit first, followed by one stop bit, and places the character in a data register. Each bit takes its value from a majority vote over three samples at the middle of the bit. If those three samples do not all agree, the character is marked noisy.

Software reaches the block through a simple synchronous register port with an address, write data, a read strobe and a write strobe. Read data is registered. A baud register selects a prescaler and a power-of-two rate divider, and together these produce the sample tick. The noise, framing and overrun flags, and the receive-full flag, are cleared only by a fixed sequence: a status read first, then a data read.

Top module: `uart_rx_status`

## Requirements
- R1: Register addresses are 0 = status, 1 = data, 2 = baud. Address 3 reads as 0. `rdata_o` holds the addressed register from the clock edge that samples `rd_i` high.
- R2: The baud register holds the prescaler select in bits 5:4 and the rate select in bits 2:0. Bits 7, 6 and 3 always read 0, so writing 0xFF reads back 0x37.
- R3: Reset clears the prescaler select and all status flags. Reset leaves the rate select at its previous value, so 0xFF written before a reset reads back 0x07 after it.
- R4: The sample tick period is P·2^N system clocks. P is 1, 3, 4 or 13 for prescaler select 0 to 3, and N is the rate select. Every bit lasts 16 ticks.
- R5: A low start bit, confirmed at mid-bit, is followed by 8 data bits sent LSB first and a stop bit. At the end of the frame the character goes into the data register and the full flag (status bit 5) sets.
- R6: Each bit takes its value from a majority vote over sample ticks 7, 8 and 9 of that bit. If the three samples disagree on any bit of the frame, the noise flag (status bit 2) sets for that character.
- R7: A stop bit sampled as 0 sets the framing flag (status bit 1).
- R8: If a character completes while the full flag is set, the overrun flag (status bit 3) sets. The new character is discarded and the data register keeps its old value.
- R9: A discarded character that also has a framing error sets only the overrun flag. The framing flag does not change.
- R10: A status read arms the clear sequence. A data read while armed clears the full, overrun, noise and framing flags and disarms. A data read while not armed changes no flag.
- R11: A status change after arming, such as a new character arriving, does not disarm the clear sequence.
- R12: The status and data registers cannot be written. Writes to addresses 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Asynchronous serial input, idles high |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
Overrun detection and framing-error detection can both happen on the same cycle, when a frame completes. The test provokes this by leaving one character unread and then sending a second character with its stop bit held low. The result is correct if the status reads 0x28, with overrun and full set and the framing flag clear, and the data register still holds the first character. A separate scenario arms the clear sequence before a character arrives. This confirms that the status change caused by the new character does not disarm the sequence.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_DATA = 2'd1,
    REG_BAUD = 2'd2
  } reg_sel_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  localparam int STAT_FULL = 5;
  localparam int STAT_OVR  = 3;
  localparam int STAT_NF   = 2;
  localparam int STAT_FE   = 1;

  function automatic logic [3:0] pre_div(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd1;
      2'd1:    return 4'd3;
      2'd2:    return 4'd4;
      default: return 4'd13;
    endcase
  endfunction
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen
  import uart_rx_pkg::*;
#(
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        pre_sel_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  output logic              tick_o
);
  localparam int RCNT_W = (1 << RATE_W) - 1;

  logic [3:0]        pre_cnt_q;
  logic [RCNT_W-1:0] rate_cnt_q, rate_mask;
  logic              pre_tick, rate_wrap;

  assign pre_tick = pre_cnt_q >= (pre_div(pre_sel_i) - 4'd1);

  always_comb begin
    rate_mask = '0;
    for (int i = 0; i < RCNT_W; i++)
      if (i < int'(rate_sel_i)) rate_mask[i] = 1'b1;
  end

  assign rate_wrap = (rate_cnt_q & rate_mask) == rate_mask;
  assign tick_o    = pre_tick && rate_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q  <= '0;
      rate_cnt_q <= '0;
    end else begin
      pre_cnt_q <= pre_tick ? 4'd0 : pre_cnt_q + 4'd1;
      if (pre_tick) rate_cnt_q <= rate_wrap ? '0 : rate_cnt_q + 1'b1;
    end
  end

  assert_fast_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_sel_i == 2'd0 && rate_sel_i == '0) |-> tick_o);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              nf_o,
  output logic              fe_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam int MID   = OVS / 2;

  rx_state_e         state_q;
  logic [1:0]        sync_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic              s_lo_q, s_mid_q, noise_q;
  logic [DATA_W-1:0] shreg_q;
  logic              rx_s, maj, dis;

  assign rx_s = sync_q[1];
  assign maj  = (s_lo_q & s_mid_q) | (s_lo_q & rx_s) | (s_mid_q & rx_s);
  assign dis  = !((s_lo_q == s_mid_q) && (s_mid_q == rx_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      s_lo_q  <= 1'b1;
      s_mid_q <= 1'b1;
      noise_q <= 1'b0;
      shreg_q <= '0;
      done_o  <= 1'b0;
      data_o  <= '0;
      nf_o    <= 1'b0;
      fe_o    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      done_o <= 1'b0;
      if (tick_i) begin
        if (state_q == RX_IDLE) begin
          if (!rx_s) begin
            state_q <= RX_BUSY;
            cnt_q   <= CNT_W'(1);
            bit_q   <= '0;
            noise_q <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(MID - 1)) s_lo_q  <= rx_s;
          if (cnt_q == CNT_W'(MID))     s_mid_q <= rx_s;
          if (cnt_q == CNT_W'(MID + 1)) begin
            noise_q <= noise_q | dis;
            if (bit_q == '0) begin
              if (maj) state_q <= RX_IDLE;  // false start
            end else if (bit_q <= BIT_W'(DATA_W)) begin
              shreg_q <= {maj, shreg_q[DATA_W-1:1]};
            end else begin
              done_o  <= 1'b1;
              data_o  <= shreg_q;
              nf_o    <= noise_q | dis;
              fe_o    <= !maj;
              state_q <= RX_IDLE;
            end
          end
          if (cnt_q == CNT_W'(OVS - 1)) bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3,
  parameter int OVS    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o
);
  logic [1:0]        pre_q;
  logic [RATE_W-1:0] rate_q;
  logic              tick;
  logic              rx_done, rx_nf, rx_fe;
  logic [DATA_W-1:0] rx_data, data_q;
  logic              full_q, ovr_q, nf_q, fe_q, armed_q;
  logic              st_rd, dt_rd, clr, baud_wr;
  logic [7:0]        rd_mux;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata_i[7:6], wdata_i[3]};

  assign st_rd   = rd_i && (addr_i == REG_STAT);
  assign dt_rd   = rd_i && (addr_i == REG_DATA);
  assign clr     = dt_rd && armed_q;
  assign baud_wr = wr_i && (addr_i == REG_BAUD);

  rx_tick_gen #(.RATE_W(RATE_W)) u_tick (
    .clk_i, .rst_ni, .pre_sel_i(pre_q), .rate_sel_i(rate_q), .tick_o(tick)
  );

  rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk_i, .rst_ni, .tick_i(tick), .rx_i,
    .done_o(rx_done), .data_o(rx_data), .nf_o(rx_nf), .fe_o(rx_fe)
  );

  // rate select deliberately survives reset
  always_ff @(posedge clk_i) begin
    if (baud_wr) rate_q <= wdata_i[RATE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (baud_wr) pre_q <= wdata_i[5:4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      full_q  <= 1'b0;
      ovr_q   <= 1'b0;
      nf_q    <= 1'b0;
      fe_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (clr) begin
        {full_q, ovr_q, nf_q, fe_q} <= '0;
        armed_q <= 1'b0;
      end else if (st_rd) begin
        armed_q <= 1'b1;
      end
      // a clearing read in the same cycle frees the register first
      if (rx_done) begin
        if (full_q && !clr) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= rx_data;
          full_q <= 1'b1;
          nf_q   <= rx_nf;
          fe_q   <= rx_fe;
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_STAT: begin
        rd_mux[STAT_FULL] = full_q;
        rd_mux[STAT_OVR]  = ovr_q;
        rd_mux[STAT_NF]   = nf_q;
        rd_mux[STAT_FE]   = fe_q;
      end
      REG_DATA: rd_mux = 8'(data_q);
      REG_BAUD: rd_mux = {2'b00, pre_q, 1'b0, 3'(rate_q)};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assert_ovr_keeps_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && full_q && !clr) |=> ($stable(data_q) && ovr_q));

  assert_ovr_masks_fe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && full_q && !clr) |=> $stable(fe_q));

  assert_unarmed_read_inert_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_rd && !armed_q && !rx_done) |=>
      ($stable(full_q) && $stable(ovr_q) && $stable(nf_q) && $stable(fe_q)));

  assert_flag_drop_needs_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(nf_q) || $fell(fe_q) || $fell(ovr_q)) |-> $past(clr));
endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;

  int n_run = 0, n_fail = 0;
  int bit_cyc = 16;
  bit finished = 0;

  typedef struct {logic [7:0] data; logic [7:0] stat; string req;} exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  uart_rx_status uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .addr_i(addr),
    .wdata_i(wdata), .wr_i(wr), .rd_i(rd), .rdata_o(rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // driver: frames one character, optionally pushing the expected result
  task automatic send(input logic [7:0] d, input logic stop, input int glitch_bit,
                      input bit push, input logic [7:0] stat, input string req);
    exp_t e;
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == 9) ? stop : d[b-1];
      for (int c = 0; c < bit_cyc; c++) begin
        @(negedge clk);
        rx = (b == glitch_bit && c == 9) ? ~v : v;
      end
    end
    @(negedge clk); rx = 1'b1;
    repeat (3 * bit_cyc) @(negedge clk);
    if (push) begin
      e.data = d; e.stat = stat; e.req = req;
      exp_q.push_back(e);
    end
  endtask

  // monitor: pops one expectation and checks it through the clear sequence
  task automatic check_rx();
    exp_t e;
    logic [7:0] v;
    e = exp_q.pop_front();
    bus_rd(2'd0, v); chk({e.req, " status"}, v, e.stat);
    bus_rd(2'd1, v); chk({e.req, " data"}, v, e.data);
    bus_rd(2'd0, v); chk("R10 cleared after sequence", v, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    bus_rd(2'd0, v); chk("R3 status after reset", v, 8'h00);
    bus_rd(2'd2, v); chk("R3 prescaler clear, R2 fixed zeros", v & 8'hF8, 8'h00);
    bus_rd(2'd3, v); chk("R1 unused address", v, 8'h00);

    bus_wr(2'd2, 8'hFF);
    bus_rd(2'd2, v); chk("R2 baud readback", v, 8'h37);
    do_reset();
    bus_rd(2'd2, v); chk("R3 rate kept over reset", v, 8'h07);

    bus_wr(2'd2, 8'h00); bit_cyc = 16;
    send(8'hA5, 1'b1, -1, 1, 8'h20, "R5 R1 plain char");
    check_rx();

    send(8'h5A, 1'b1, 4, 1, 8'h24, "R6 noise");
    check_rx();

    send(8'h3C, 1'b0, -1, 1, 8'h22, "R7 framing");
    check_rx();

    send(8'h11, 1'b1, -1, 1, 8'h28, "R8 overrun");
    send(8'h22, 1'b1, -1, 0, 8'h00, "");
    check_rx();

    send(8'h33, 1'b1, -1, 1, 8'h28, "R9 overrun over framing");
    send(8'h44, 1'b0, -1, 0, 8'h00, "");
    check_rx();

    // disarm, then an unarmed data read must not clear
    bus_rd(2'd1, v);
    send(8'h66, 1'b1, -1, 0, 8'h00, "");
    bus_rd(2'd1, v); chk("R10 data unarmed", v, 8'h66);
    bus_wr(2'd0, 8'h00);
    bus_rd(2'd0, v); chk("R10 unarmed read keeps full", v, 8'h20);
    bus_rd(2'd1, v);
    bus_rd(2'd0, v); chk("R10 armed read clears", v, 8'h00);

    // armed before arrival
    send(8'h77, 1'b1, -1, 0, 8'h00, "");
    bus_rd(2'd1, v); chk("R11 data", v, 8'h77);
    bus_rd(2'd0, v); chk("R11 still armed, cleared", v, 8'h00);

    send(8'h81, 1'b1, -1, 1, 8'h20, "R12 writes ignored");
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd0, 8'hFF);
    check_rx();

    bus_wr(2'd2, 8'h11); bit_cyc = 96;
    send(8'hC3, 1'b1, -1, 1, 8'h20, "R4 divide 3x2");
    check_rx();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule